// File: doc/BRIEF.md
# I2C Slave Register Access Front-End

This block connects a small register file to a two-wire I2C bus as a slave. SCL and SDA are sampled with the system clock and passed through a synchroniser and a glitch filter. From the filtered lines the block detects START, repeated START and STOP conditions, and it matches the device address against a fixed prefix and three strap inputs. The register file itself sits outside the block. The block drives it through a write strobe with address and data, and a read strobe with an address, and takes the read data back the same cycle.

A transfer first loads an internal register pointer from a register address byte. After that, each data byte written or read moves the pointer on by one. Past the last address (8 by default) the pointer returns to 0. The block drives SDA only as an open-drain pull-down enable, for ACK bits and for the zero bits of read data. While the surrounding logic still reports power-up in progress, the block does not accept START conditions. While the register file reports busy, the block refuses write data bytes.

Top module: `i2c_reg_slave`

## Requirements
- R1: The first byte after a START is accepted (ACK) only when its bits 7..4 are 1010 and bits 3..1 equal strap_i[2:1:0]. Bit 0 selects a read (1) or a write (0). On a mismatch the block sends no ACK, does not drive SDA, and ignores the bus until the next START.
- R2: The block ACKs the register address byte, and it ACKs every write data byte it accepts.
- R3: Each accepted write data byte produces a one-cycle wr_en_o pulse. The pulse carries the current pointer on wr_addr_o and the byte on wr_data_o. The pointer then advances.
- R4: A read is START, address with bit 0 = 0, register address, repeated START, address with bit 0 = 1. Data bytes from consecutive addresses follow for as long as the master ACKs. A master NACK ends the read.
- R5: When the pointer holds LAST_ADDR (or a larger value), the next increment sets it to 0. This applies to both reads and writes.
- R6: Bytes travel MSB first. Input bits are taken on the SCL rising edge, and sda_pd_o changes only while the filtered SCL is low.
- R7: A pulse on SCL or SDA that lasts fewer than FILT_CYC clock cycles is neither an edge nor a condition.
- R8: While init_done_i is low, START conditions are ignored, so the block neither ACKs nor writes.
- R9: If busy_i is high when a write data byte completes, the byte gets a NACK, no wr_en_o pulse occurs, the pointer stays unchanged and the bus is ignored until the next START.
- R10: sda_pd_o is an active-high pull-down enable. It is low in reset and in idle, and after every STOP.
- R11: rd_en_o pulses for one cycle when a read byte is loaded, with rd_addr_o naming the register. The pointer then advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | High once power-up is complete |
| strap_i | input | 3 | Low three device address bits |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pd_o | output | 1 | Pull-down enable for SDA (1 = drive low) |
| busy_i | input | 1 | Register file cannot accept writes |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 8 | Write data |
| rd_en_o | output | 1 | Read strobe |
| rd_addr_o | output | 8 | Read address (current pointer) |
| rd_data_i | input | 8 | Read data for rd_addr_o, same cycle |

## Verification
The bench builds the block with FILT_CYC = 4 and LAST_ADDR = 8, and runs the bus at 10 system clocks per quarter SCL period. The short filter keeps each bit to 40 cycles, so many random multi-byte transfers fit in the run, and transfers of up to twelve bytes cross the 8-to-0 wrap several times. A 2-cycle glitch is below the filter length, which makes suppression directly observable on both lines. The small address range lets the bench's model of the register contents cover every register.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_REG, ST_REG_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } st_e;

  function automatic logic [BYTE_W-1:0] ptr_inc(input logic [BYTE_W-1:0] p,
                                                input logic [BYTE_W-1:0] last);
    return (p >= last) ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/i2c_rs_filt.sv
module i2c_rs_filt #(
  parameter int FILT_CYC = 10,
  parameter int SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0]       cnt_q;
  logic                out_q;
  logic                smp;

  assign smp   = sync_q[SYNC_LEN-1];
  assign out_o = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], in_i};
      // output follows only after FILT_CYC consecutive differing samples
      if (smp != out_q) begin
        if (cnt_q == CW'(FILT_CYC - 1)) begin
          out_q <= smp;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;
endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
  import i2c_rs_pkg::*;
#(
  parameter logic [3:0]        DEV_PREFIX = 4'b1010,
  parameter logic [BYTE_W-1:0] LAST_ADDR  = 8'd8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic [2:0]        strap_i,
  input  logic              sda_f_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_pd_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [BYTE_W-1:0] rd_addr_o
);
  localparam logic [3:0] FULL = 4'(BYTE_W);

  st_e               st_q;
  logic [3:0]        bcnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, ptr_q, ptr_nx;
  logic              rw_q, mack_q, pd_q;
  logic              load;

  assign ptr_nx    = ptr_inc(ptr_q, LAST_ADDR);
  assign rd_addr_o = ptr_q;
  assign sda_pd_o  = pd_q;
  // first byte after read address ACK, or next byte after master ACK
  assign load = fall_i && (((st_q == ST_DEV_ACK) && rw_q) ||
                           ((st_q == ST_RD_ACK) && mack_q));
  assign rd_en_o = load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bcnt_q    <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      pd_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i && init_done_i) begin
        st_q   <= ST_DEV;
        bcnt_q <= '0;
        pd_q   <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        pd_q <= 1'b0;
      end else if (rise_i) begin
        case (st_q)
          ST_DEV, ST_REG, ST_WR, ST_RD: begin
            if (bcnt_q != FULL) begin
              sh_q   <= {sh_q[BYTE_W-2:0], sda_f_i};
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
          ST_RD_ACK: mack_q <= ~sda_f_i;
          default: ;
        endcase
      end else if (fall_i) begin
        case (st_q)
          ST_DEV: begin
            if (bcnt_q == FULL) begin
              if (sh_q[7:1] == {DEV_PREFIX, strap_i}) begin
                rw_q <= sh_q[0];
                pd_q <= 1'b1;
                st_q <= ST_DEV_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_REG: begin
            if (bcnt_q == FULL) begin
              ptr_q <= sh_q;
              pd_q  <= 1'b1;
              st_q  <= ST_REG_ACK;
            end
          end
          ST_WR: begin
            if (bcnt_q == FULL) begin
              if (!busy_i) begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr_q;
                wr_data_o <= sh_q;
                ptr_q     <= ptr_nx;
                pd_q      <= 1'b1;
                st_q      <= ST_WR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_REG_ACK, ST_WR_ACK: begin
            pd_q   <= 1'b0;
            bcnt_q <= '0;
            st_q   <= ST_WR;
          end
          ST_DEV_ACK, ST_RD_ACK: begin
            bcnt_q <= '0;
            if (load) begin
              tx_q  <= rd_data_i;
              pd_q  <= ~rd_data_i[BYTE_W-1];
              ptr_q <= ptr_nx;
              st_q  <= ST_RD;
            end else begin
              pd_q <= 1'b0;
              st_q <= (st_q == ST_DEV_ACK) ? ST_REG : ST_IDLE;
            end
          end
          ST_RD: begin
            if (bcnt_q == FULL) begin
              pd_q   <= 1'b0;
              bcnt_q <= '0;
              st_q   <= ST_RD_ACK;
            end else begin
              pd_q <= ~tx_q[BYTE_W-2];
              tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_rs_pkg::*;
#(
  parameter int          FILT_CYC   = 10,
  parameter int          SYNC_LEN   = 2,
  parameter logic [3:0]  DEV_PREFIX = 4'b1010,
  parameter logic [7:0]  LAST_ADDR  = 8'd8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_done_i,
  input  logic [2:0] strap_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pd_o,
  input  logic       busy_i,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       rd_en_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] line_raw, line_f;
  logic scl_f, sda_f;
  logic start, stop, rise, fall;

  assign line_raw = {scl_i, sda_i};
  assign scl_f    = line_f[1];
  assign sda_f    = line_f[0];

  for (genvar g = 0; g < NLINE; g++) begin : g_filt
    i2c_rs_filt #(.FILT_CYC(FILT_CYC), .SYNC_LEN(SYNC_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (line_raw[g]),
      .out_o (line_f[g])
    );
  end

  i2c_rs_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_f),
    .sda_i  (sda_f),
    .start_o(start),
    .stop_o (stop),
    .rise_o (rise),
    .fall_o (fall)
  );

  i2c_rs_fsm #(.DEV_PREFIX(DEV_PREFIX), .LAST_ADDR(LAST_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_done_i(init_done_i),
    .strap_i    (strap_i),
    .sda_f_i    (sda_f),
    .start_i    (start),
    .stop_i     (stop),
    .rise_i     (rise),
    .fall_i     (fall),
    .busy_i     (busy_i),
    .rd_data_i  (rd_data_i),
    .sda_pd_o   (sda_pd_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o)
  );
endmodule

// File: rtl/i2c_rs_chk.sv
module i2c_rs_chk
  import i2c_rs_pkg::*;
#(
  parameter logic [7:0] LAST_ADDR = 8'd8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_f_i,
  input logic       sda_pd_i,
  input logic       init_done_i,
  input logic       busy_i,
  input logic       wr_en_i,
  input logic [7:0] wr_addr_i,
  input logic       rd_en_i,
  input logic [7:0] rd_addr_i
);
  logic init_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_seen_q <= 1'b0;
    else if (init_done_i) init_seen_q <= 1'b1;
  end

  // R3 R5
  wr_ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> rd_addr_i == ptr_inc(wr_addr_i, LAST_ADDR));

  // R11
  rd_ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_addr_i == ptr_inc($past(rd_addr_i), LAST_ADDR));

  // R9
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !$past(busy_i));

  // R6
  pd_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd_i) |-> !$past(scl_f_i));

  // R8
  no_drive_pre_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_seen_q |-> !sda_pd_i && !wr_en_i);
endmodule

bind i2c_reg_slave i2c_rs_chk #(.LAST_ADDR(LAST_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_f_i    (scl_f),
  .sda_pd_i   (sda_pd_o),
  .init_done_i(init_done_i),
  .busy_i     (busy_i),
  .wr_en_i    (wr_en_o),
  .wr_addr_i  (wr_addr_o),
  .rd_en_i    (rd_en_o),
  .rd_addr_i  (rd_addr_o)
);

// File: tb/tb_i2c_reg_slave.sv
`timescale 1ns/1ps
module tb_i2c_reg_slave;
  localparam int         FILT = 4;
  localparam int         Q    = 10;
  localparam logic [7:0] LAST = 8'd8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_done = 1'b0, busy = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pd, wr_en, rd_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic sda_line;
  logic [7:0] rf [0:8];
  logic [7:0] exp_mem [0:8];
  int n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0;
  int glitch = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pd;
  assign rd_data  = (rd_addr <= LAST) ? rf[rd_addr] : 8'h00;

  i2c_reg_slave #(.FILT_CYC(FILT), .LAST_ADDR(LAST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done), .strap_i(STRAP),
    .scl_i(scl_m), .sda_i(sda_line), .sda_pd_o(sda_pd), .busy_i(busy),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  always @(posedge clk) begin
    if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      if (wr_addr <= LAST) rf[wr_addr] <= wr_data;
    end
    if (rd_en) rd_cnt <= rd_cnt + 1;
  end

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (p >= LAST) ? 8'd0 : p + 8'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  // glitch 1: SDA flips briefly while SCL high; glitch 2: short SCL pulse while low
  task automatic put_bit(input logic b, output logic smp);
    sda_m = b;
    if (glitch == 2) begin
      w(Q/2 - FILT); scl_m = 1'b1; w(FILT - 2); scl_m = 1'b0; w(Q/2 + 2);
    end else w(Q);
    scl_m = 1'b1;
    if (glitch == 1) begin
      w(Q/2); sda_m = ~b; w(FILT - 2); sda_m = b; w(Q/2 - FILT + 2);
    end else w(Q);
    smp = sda_line;
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(d[i], s);
    put_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin put_bit(1'b1, s); d[i] = s; end
    put_bit(~mack, s);
  endtask

  task automatic wr_txn(input logic [7:0] a, input int n, input string req);
    logic ack; logic [7:0] p, d;
    int wc0;
    wc0 = wr_cnt;
    p = a;
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); chk(ack, "R1", ack, 1);
    send_byte(a, ack); chk(ack, "R2", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk(ack, req, ack, 1);
      exp_mem[p] = d; p = nxt(p);
    end
    bus_stop(); w(2*Q);
    chk(wr_cnt - wc0 == n, "R3", wr_cnt - wc0, n);
    chk(sda_pd == 1'b0, "R10", sda_pd, 0);
  endtask

  task automatic rd_txn(input logic [7:0] a, input int n, input string req);
    logic ack; logic [7:0] p, d;
    int rc0;
    rc0 = rd_cnt;
    p = a;
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); chk(ack, "R1", ack, 1);
    send_byte(a, ack); chk(ack, "R2", ack, 1);
    bus_start();
    send_byte({4'hA, STRAP, 1'b1}, ack); chk(ack, "R4", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      chk(d == exp_mem[p], req, d, exp_mem[p]);
      p = nxt(p);
    end
    bus_stop(); w(2*Q);
    chk(rd_cnt - rc0 == n, "R11", rd_cnt - rc0, n);
  endtask

  initial begin : main
    logic ack;
    int wc0;
    void'($urandom(32'd2024));
    for (int i = 0; i <= 8; i++) begin rf[i] = 8'(i * 17 + 3); exp_mem[i] = 8'(i * 17 + 3); end
    w(5);
    chk(sda_pd == 1'b0 && wr_en == 1'b0, "R10", sda_pd, 0);
    rst_n = 1'b1; w(5);
    chk(sda_pd == 1'b0, "R10", sda_pd, 0);

    // R8: no START accepted before init completes
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); chk(!ack, "R8", ack, 0);
    send_byte(8'h02, ack); chk(!ack, "R8", ack, 0);
    send_byte(8'h55, ack); chk(!ack, "R8", ack, 0);
    bus_stop();
    chk(wr_cnt == 0, "R8", wr_cnt, 0);
    init_done = 1'b1; w(Q);

    // R6 MSB-first patterns
    rf[0] = 8'h00; exp_mem[0] = 8'h00;
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack); chk(ack, "R1", ack, 1);
    send_byte(8'h00, ack);
    send_byte(8'h80, ack); exp_mem[0] = 8'h80;
    send_byte(8'h01, ack); exp_mem[1] = 8'h01;
    bus_stop(); w(2*Q);
    chk(rf[0] == 8'h80 && rf[1] == 8'h01, "R6", {rf[0], rf[1]}, 16'h8001);
    rd_txn(8'h00, 2, "R6");

    // R5 wrap on writes and reads
    wr_txn(8'd7, 4, "R5");
    chk(rf[0] == exp_mem[0] && rf[8] == exp_mem[8], "R5", rf[0], exp_mem[0]);
    rd_txn(8'd8, 3, "R5");

    // R1 mismatch: wrong strap, then wrong prefix
    wc0 = wr_cnt;
    bus_start();
    send_byte({4'hA, STRAP ^ 3'b010, 1'b0}, ack); chk(!ack, "R1", ack, 0);
    send_byte(8'h03, ack); chk(!ack, "R1", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'hB, STRAP, 1'b0}, ack); chk(!ack, "R1", ack, 0);
    bus_stop(); w(2*Q);
    chk(wr_cnt == wc0, "R1", wr_cnt, wc0);

    // R9 busy refuses write data
    wc0 = wr_cnt;
    bus_start();
    send_byte({4'hA, STRAP, 1'b0}, ack);
    send_byte(8'h03, ack); chk(ack, "R2", ack, 1);
    busy = 1'b1;
    send_byte(8'hC3, ack); chk(!ack, "R9", ack, 0);
    send_byte(8'h3C, ack); chk(!ack, "R9", ack, 0);
    bus_stop(); busy = 1'b0; w(2*Q);
    chk(wr_cnt == wc0, "R9", wr_cnt, wc0);
    rd_txn(8'h03, 1, "R9");

    // R7 glitches on SDA (high phase) and SCL (low phase)
    glitch = 1; wr_txn(8'h04, 2, "R7"); glitch = 0;
    rd_txn(8'h04, 2, "R7");
    glitch = 2; wr_txn(8'h02, 2, "R7"); glitch = 0;
    rd_txn(8'h02, 2, "R7");

    // random mix
    for (int t = 0; t < 24; t++) begin
      logic [7:0] a; int n;
      a = 8'($urandom_range(0, 8));
      n = $urandom_range(1, 12);
      if ($urandom_range(0, 1) == 1) wr_txn(a, n, "R3");
      else rd_txn(a, n, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule